// File: doc/BRIEF.md
# Core Register Command Bridge

This block lets a host reach a small bank of 8-bit two-wire bus controller registers through one 64-bit command word rather than through a flat address map. The host writes the command word with its top bit set. The bridge decodes a primary opcode, and where needed a secondary opcode, to choose one register. It performs a single read or write of that register and then clears the top bit. The host polls that bit to learn that the access is done, and then finds any read value in the low byte of the same word.

The bank holds five things: the data byte, the control byte, the clock-control byte, the status byte and the SCL high-period byte. A secondary opcode also issues a controller reset, which returns the status to idle. The bus engine is not part of this block. It reports start and stop completion, raises the event flag, loads status and loads received data through plain input ports. A separate core interrupt enable produces an interrupt whenever the status is not idle.

Top module: `corereg_bridge`

## Requirements
- R1: A `cmd_wr` pulse whose bit 63 is 1 launches an access. Bit 63 of `cmd_rdata` reads 1 after the capturing edge and after the next edge, and reads 0 after the edge that follows.
- R2: Bit 56 set means read and clear means write. With primary opcode 6 (bits 60:57), secondary opcode 1 (bits 34:32) selects the data byte and 2 selects the control byte. The write byte is taken from bits 7:0.
- R3: With primary opcode 6 and secondary opcode 3, a write goes to the clock-control byte and a read returns the status byte.
- R4: Primary opcode 4 writes the SCL high-period byte, and a read with the same opcode returns it.
- R5: On completion, `cmd_rdata` holds bit 63 = 0, bits 60:57 = the opcode, bit 56 = the read flag, and zero in all other upper bits. Bits 7:0 hold the read value, or 0 after a write.
- R6: A write with primary opcode 6 and secondary opcode 7 sets status to 0xF8, clears the control and data bytes, and pulses `core_rst_o` for exactly one cycle. The clock bytes are kept.
- R7: A command written while bit 63 still reads 1 is ignored, and the access in progress completes unchanged.
- R8: Control bit 5 (start) clears on `eng_start_done` and bit 4 (stop) clears on `eng_stop_done`. Bit 3 (event flag) sets on `eng_iflg_set`. A host write of 0 to bit 3 clears it, and a host write of 1 leaves it as it was.
- R9: `core_irq` is high exactly when interrupt-register bit 6 is set and status is not 0xF8.
- R10: Unused opcodes (primary other than 4 and 6, and secondary 0, 4, 5, 6) change no register and return 0 in bits 7:0.
- R11: After reset, status is 0xF8, all other registers are 0, and `cmd_rdata` is 0.
- R12: A `cmd_wr` pulse with bit 63 clear starts nothing and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Host write strobe for the command word |
| cmd_wdata | input | 64 | Command word written by the host |
| cmd_rdata | output | 64 | Command/status word as read by the host |
| int_wr | input | 1 | Host write strobe for the interrupt register |
| int_wdata | input | 8 | Interrupt register value, bit 6 is the core enable |
| eng_stat_we | input | 1 | Engine loads a new status byte |
| eng_stat | input | 8 | Status byte from the engine |
| eng_rx_we | input | 1 | Engine loads a received data byte |
| eng_rx_data | input | 8 | Received data byte |
| eng_start_done | input | 1 | Engine finished a start condition |
| eng_stop_done | input | 1 | Engine finished a stop condition |
| eng_iflg_set | input | 1 | Engine raises the event flag |
| ctl_o | output | 8 | Control byte |
| data_o | output | 8 | Data byte |
| clkctl_o | output | 8 | Clock-control byte |
| sclhi_o | output | 8 | SCL high-period byte |
| core_rst_o | output | 1 | One-cycle controller reset pulse |
| core_irq | output | 1 | Core interrupt |

## Verification
Each register is written and read back using a distinct byte value, so a decode that picks the wrong target shows up as a wrong value rather than as a plausible one. Secondary opcode 3 is tried both as a write and as a read, which tells the clock-control byte apart from the status byte. The control byte is driven from both the host side and the engine side in sequence, which separates the self-clearing start and stop bits from the event flag, including a host write of 1 while the flag is clear. A second command written mid-access, a command with its top bit clear, and unused opcodes each show whether an access leaked through when none should have.

// File: rtl/crb_pkg.sv
// Shared constants and types for the core register command bridge.
// Assumes a 64-bit command word and 8-bit core registers.
package crb_pkg;
    localparam int CMD_W   = 64;
    localparam int REG_W   = 8;
    localparam int VLD_BIT = 63;
    localparam int RD_BIT  = 56;
    localparam int OP_LSB  = 57;
    localparam int OP_W    = 4;
    localparam int EXT_LSB = 32;
    localparam int EXT_W   = 3;
    localparam int PAD_W   = CMD_W - 1 - 2 - OP_W - 1 - REG_W;

    localparam logic [OP_W-1:0]  OP_SCLHI = 4'd4;
    localparam logic [OP_W-1:0]  OP_EXT   = 4'd6;
    localparam logic [EXT_W-1:0] EXT_DATA = 3'd1;
    localparam logic [EXT_W-1:0] EXT_CTL  = 3'd2;
    localparam logic [EXT_W-1:0] EXT_CLK  = 3'd3;
    localparam logic [EXT_W-1:0] EXT_RST  = 3'd7;

    localparam logic [REG_W-1:0] STAT_IDLE = 8'hF8;
    localparam int CTL_START = 5;
    localparam int CTL_STOP  = 4;
    localparam int CTL_FLAG  = 3;
    localparam int INT_EN    = 6;

    typedef enum logic [2:0] {
        TGT_NONE, TGT_DATA, TGT_CTL, TGT_CLK, TGT_STAT, TGT_SCLHI, TGT_RST
    } tgt_e;

    typedef struct packed {
        logic              rd;
        logic [OP_W-1:0]   op;
        logic [EXT_W-1:0]  ext;
        logic [REG_W-1:0]  wbyte;
    } cmd_t;
endpackage

// File: rtl/crb_decode.sv
// Two-level opcode decode: maps a latched command onto one register target.
// Purely combinational; assumes the command is stable while it is in flight.
module crb_decode
    import crb_pkg::*;
(
    input  cmd_t cmd,
    output tgt_e tgt
);
    // Pick the target from the primary opcode, then the secondary one
    always_comb begin
        tgt = TGT_NONE;
        if (cmd.op == OP_SCLHI) begin
            tgt = TGT_SCLHI;
        end else if (cmd.op == OP_EXT) begin
            case (cmd.ext)
                EXT_DATA: tgt = TGT_DATA;
                EXT_CTL:  tgt = TGT_CTL;
                EXT_CLK:  tgt = cmd.rd ? TGT_STAT : TGT_CLK;
                EXT_RST:  tgt = cmd.rd ? TGT_NONE : TGT_RST;
                default:  tgt = TGT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/crb_seq.sv
// Launch and completion sequencer. It captures a command whose valid bit
// is set, issues one execute cycle, and clears valid on the cycle after.
// Assumes the register bank answers a read in the execute cycle.
module crb_seq
    import crb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic [REG_W-1:0] rd_byte,
    output cmd_t             cmd,
    output logic             exec,
    output logic [CMD_W-1:0] cmd_rdata
);
    logic             busy_q;
    logic             phase_q;
    logic [REG_W-1:0] byte_q;
    logic             launch;
    logic             unused_bits;

    assign launch      = cmd_wr && cmd_wdata[VLD_BIT] && !busy_q;
    assign exec        = busy_q && !phase_q;
    assign unused_bits = ^{cmd_wdata[62:61], cmd_wdata[55:35], cmd_wdata[31:8]};

    // Command capture, two-cycle sequencing and result byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            byte_q  <= '0;
            cmd     <= '0;
        end else if (launch) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            byte_q  <= '0;
            cmd     <= '{rd:    cmd_wdata[RD_BIT],
                         op:    cmd_wdata[OP_LSB +: OP_W],
                         ext:   cmd_wdata[EXT_LSB +: EXT_W],
                         wbyte: cmd_wdata[REG_W-1:0]};
        end else if (busy_q) begin
            if (!phase_q) begin
                phase_q <= 1'b1;
                byte_q  <= cmd.rd ? rd_byte : '0;
            end else begin
                busy_q  <= 1'b0;
            end
        end
    end

    assign cmd_rdata = {busy_q, 2'b00, cmd.op, cmd.rd, {PAD_W{1'b0}}, byte_q};

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cmd_wr) |=> $stable(cmd));

    // R1
    valid_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_rdata[VLD_BIT]) |-> ($past(cmd_rdata[VLD_BIT], 2) && !$past(cmd_rdata[VLD_BIT], 3)));
endmodule

// File: rtl/crb_regbank.sv
// Core register bank: data, control, clock-control, status and SCL
// high-period bytes plus the core interrupt enable. Host writes arrive
// in the execute cycle and take priority over engine updates.
module crb_regbank
    import crb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  tgt_e             tgt,
    input  logic [REG_W-1:0] wbyte,
    input  logic             int_wr,
    input  logic [REG_W-1:0] int_wdata,
    input  logic             eng_stat_we,
    input  logic [REG_W-1:0] eng_stat,
    input  logic             eng_rx_we,
    input  logic [REG_W-1:0] eng_rx_data,
    input  logic             eng_start_done,
    input  logic             eng_stop_done,
    input  logic             eng_iflg_set,
    output logic [REG_W-1:0] rd_byte,
    output logic [REG_W-1:0] ctl_o,
    output logic [REG_W-1:0] data_o,
    output logic [REG_W-1:0] clkctl_o,
    output logic [REG_W-1:0] sclhi_o,
    output logic             core_rst_o,
    output logic             core_irq
);
    logic [REG_W-1:0] stat_q;
    logic             irq_en_q;
    logic             rst_cmd;
    logic             ctl_wr;
    logic             unused_int;

    assign rst_cmd    = wr_en && (tgt == TGT_RST);
    assign ctl_wr     = wr_en && (tgt == TGT_CTL);
    assign unused_int = ^{int_wdata[7], int_wdata[5:0]};

    // Control byte: host write, engine self-clear and flag set
    always_ff @(posedge clk) begin
        if (!rst_n || rst_cmd) begin
            ctl_o <= '0;
        end else if (ctl_wr) begin
            ctl_o <= {wbyte[7:4], wbyte[CTL_FLAG] & ctl_o[CTL_FLAG], wbyte[2:0]};
        end else begin
            if (eng_start_done) ctl_o[CTL_START] <= 1'b0;
            if (eng_stop_done)  ctl_o[CTL_STOP]  <= 1'b0;
            if (eng_iflg_set)   ctl_o[CTL_FLAG]  <= 1'b1;
        end
    end

    // Data byte: host write wins over received data
    always_ff @(posedge clk) begin
        if (!rst_n || rst_cmd)                 data_o <= '0;
        else if (wr_en && tgt == TGT_DATA)     data_o <= wbyte;
        else if (eng_rx_we)                    data_o <= eng_rx_data;
    end

    // Status byte: reset command forces idle, else engine loads
    always_ff @(posedge clk) begin
        if (!rst_n || rst_cmd) stat_q <= STAT_IDLE;
        else if (eng_stat_we)  stat_q <= eng_stat;
    end

    // Clock bytes, interrupt enable and reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clkctl_o   <= '0;
            sclhi_o    <= '0;
            irq_en_q   <= 1'b0;
            core_rst_o <= 1'b0;
        end else begin
            if (wr_en && tgt == TGT_CLK)   clkctl_o <= wbyte;
            if (wr_en && tgt == TGT_SCLHI) sclhi_o  <= wbyte;
            if (int_wr)                    irq_en_q <= int_wdata[INT_EN];
            core_rst_o <= rst_cmd;
        end
    end

    // Read multiplexer for the selected target
    always_comb begin
        case (tgt)
            TGT_DATA:  rd_byte = data_o;
            TGT_CTL:   rd_byte = ctl_o;
            TGT_STAT:  rd_byte = stat_q;
            TGT_SCLHI: rd_byte = sclhi_o;
            default:   rd_byte = '0;
        endcase
    end

    assign core_irq = irq_en_q && (stat_q != STAT_IDLE);

    // R8
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start_done && !ctl_wr) |=> !ctl_o[CTL_START]);

    // R8
    flag_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_o[CTL_FLAG]) |=> !ctl_o[CTL_FLAG]);

    // R6
    rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> (core_irq == 1'b0 && ctl_o == '0 && data_o == '0));

    // R6
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |=> !core_rst_o);
endmodule

// File: rtl/corereg_bridge.sv
// Top of the core register command bridge: sequencer, decoder and bank.
// Assumes the host holds off a new command until the valid bit reads 0.
module corereg_bridge
    import crb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    output logic [CMD_W-1:0] cmd_rdata,
    input  logic             int_wr,
    input  logic [REG_W-1:0] int_wdata,
    input  logic             eng_stat_we,
    input  logic [REG_W-1:0] eng_stat,
    input  logic             eng_rx_we,
    input  logic [REG_W-1:0] eng_rx_data,
    input  logic             eng_start_done,
    input  logic             eng_stop_done,
    input  logic             eng_iflg_set,
    output logic [REG_W-1:0] ctl_o,
    output logic [REG_W-1:0] data_o,
    output logic [REG_W-1:0] clkctl_o,
    output logic [REG_W-1:0] sclhi_o,
    output logic             core_rst_o,
    output logic             core_irq
);
    cmd_t             cmd;
    tgt_e             tgt;
    logic             exec;
    logic [REG_W-1:0] rd_byte;

    crb_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .rd_byte(rd_byte), .cmd(cmd), .exec(exec), .cmd_rdata(cmd_rdata)
    );

    crb_decode u_dec (.cmd(cmd), .tgt(tgt));

    crb_regbank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(exec && !cmd.rd), .tgt(tgt),
        .wbyte(cmd.wbyte), .int_wr(int_wr), .int_wdata(int_wdata),
        .eng_stat_we(eng_stat_we), .eng_stat(eng_stat),
        .eng_rx_we(eng_rx_we), .eng_rx_data(eng_rx_data),
        .eng_start_done(eng_start_done), .eng_stop_done(eng_stop_done),
        .eng_iflg_set(eng_iflg_set), .rd_byte(rd_byte), .ctl_o(ctl_o),
        .data_o(data_o), .clkctl_o(clkctl_o), .sclhi_o(sclhi_o),
        .core_rst_o(core_rst_o), .core_irq(core_irq)
    );
endmodule

// File: tb/corereg_bridge_tb.sv
module corereg_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [63:0] cmd_wdata = '0;
    logic [63:0] cmd_rdata;
    logic        int_wr = 1'b0;
    logic [7:0]  int_wdata = '0;
    logic        eng_stat_we = 1'b0;
    logic [7:0]  eng_stat = '0;
    logic        eng_rx_we = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        eng_start_done = 1'b0;
    logic        eng_stop_done = 1'b0;
    logic        eng_iflg_set = 1'b0;
    logic [7:0]  ctl_o, data_o, clkctl_o, sclhi_o;
    logic        core_rst_o, core_irq;
    int          n_cmp = 0;
    int          n_bad = 0;
    int          rst_pulses = 0;
    logic [63:0] res;

    always #10 clk = ~clk;

    corereg_bridge u_dut (.*);

    always @(posedge clk) if (core_rst_o) rst_pulses <= rst_pulses + 1;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic rd, input logic [3:0] op,
                                       input logic [2:0] ext, input logic [7:0] b);
        logic [63:0] w = '0;
        w[63] = 1'b1; w[56] = rd; w[60:57] = op; w[34:32] = ext; w[7:0] = b;
        return w;
    endfunction

    function automatic logic [63:0] rslt(input logic rd, input logic [3:0] op, input logic [7:0] b);
        logic [63:0] w = '0;
        w[60:57] = op; w[56] = rd; w[7:0] = b;
        return w;
    endfunction

    // R1: launch, check valid window, return completed word
    task automatic do_cmd(input logic [63:0] w, output logic [63:0] r);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
        @(negedge clk); cmd_wr = 1'b0;
        chk("R1 valid after launch edge", {63'd0, cmd_rdata[63]}, 64'd1);
        @(negedge clk);
        chk("R1 valid second cycle", {63'd0, cmd_rdata[63]}, 64'd1);
        @(negedge clk);
        chk("R1 valid cleared", {63'd0, cmd_rdata[63]}, 64'd0);
        r = cmd_rdata;
    endtask

    task automatic t_reset;
        chk("R11 cmd_rdata", cmd_rdata, 64'd0);
        chk("R11 ctl", {56'd0, ctl_o}, 64'd0);
        chk("R11 irq", {63'd0, core_irq}, 64'd0);
        do_cmd(mk(1, 6, 3, 8'h00), res);
        chk("R11 status idle", {56'd0, res[7:0]}, 64'hF8);
    endtask

    task automatic t_data;
        do_cmd(mk(0, 6, 1, 8'h5A), res);
        chk("R2 data written", {56'd0, data_o}, 64'h5A);
        chk("R5 write result", res, rslt(0, 6, 8'h00));
        do_cmd(mk(1, 6, 1, 8'hFF), res);
        chk("R5 read result word", res, rslt(1, 6, 8'h5A));
    endtask

    task automatic t_clk;
        do_cmd(mk(0, 6, 3, 8'h2B), res);
        chk("R3 clock-control written", {56'd0, clkctl_o}, 64'h2B);
        do_cmd(mk(1, 6, 3, 8'h00), res);
        chk("R3 read returns status", {56'd0, res[7:0]}, 64'hF8);
    endtask

    task automatic t_scl;
        do_cmd(mk(0, 4, 0, 8'h18), res);
        chk("R4 scl high written", {56'd0, sclhi_o}, 64'h18);
        do_cmd(mk(1, 4, 0, 8'h00), res);
        chk("R4 scl high read", res, rslt(1, 4, 8'h18));
    endtask

    task automatic eng_pulse(input int which);
        @(negedge clk);
        eng_start_done = (which == 0); eng_stop_done = (which == 1); eng_iflg_set = (which == 2);
        @(negedge clk);
        eng_start_done = 0; eng_stop_done = 0; eng_iflg_set = 0;
    endtask

    task automatic t_ctl;
        do_cmd(mk(0, 6, 2, 8'h74), res);
        chk("R2 control written", {56'd0, ctl_o}, 64'h74);
        eng_pulse(0);
        chk("R8 start self-clear", {56'd0, ctl_o}, 64'h54);
        eng_pulse(1);
        chk("R8 stop self-clear", {56'd0, ctl_o}, 64'h44);
        eng_pulse(2);
        chk("R8 flag set by engine", {56'd0, ctl_o}, 64'h4C);
        do_cmd(mk(0, 6, 2, 8'h4C), res);
        chk("R8 write 1 keeps flag", {56'd0, ctl_o}, 64'h4C);
        do_cmd(mk(1, 6, 2, 8'h00), res);
        chk("R2 control read", {56'd0, res[7:0]}, 64'h4C);
        do_cmd(mk(0, 6, 2, 8'h44), res);
        chk("R8 write 0 clears flag", {56'd0, ctl_o}, 64'h44);
        do_cmd(mk(0, 6, 2, 8'h48), res);
        chk("R8 write 1 cannot set flag", {56'd0, ctl_o}, 64'h40);
    endtask

    task automatic t_irq;
        @(negedge clk); int_wr = 1; int_wdata = 8'h40;
        @(negedge clk); int_wr = 0;
        chk("R9 enabled, idle", {63'd0, core_irq}, 64'd0);
        @(negedge clk); eng_stat_we = 1; eng_stat = 8'h08;
        @(negedge clk); eng_stat_we = 0;
        chk("R9 enabled, busy status", {63'd0, core_irq}, 64'd1);
        @(negedge clk); int_wr = 1; int_wdata = 8'hBF;
        @(negedge clk); int_wr = 0;
        chk("R9 disabled", {63'd0, core_irq}, 64'd0);
    endtask

    task automatic t_rst;
        do_cmd(mk(0, 6, 1, 8'h33), res);
        do_cmd(mk(0, 6, 2, 8'h40), res);
        rst_pulses = 0;
        do_cmd(mk(0, 6, 7, 8'h00), res);
        @(negedge clk);
        chk("R6 one reset pulse", rst_pulses, 1);
        chk("R6 control cleared", {56'd0, ctl_o}, 64'd0);
        chk("R6 data cleared", {56'd0, data_o}, 64'd0);
        chk("R6 clock-control kept", {56'd0, clkctl_o}, 64'h2B);
        do_cmd(mk(1, 6, 3, 8'h00), res);
        chk("R6 status idle", {56'd0, res[7:0]}, 64'hF8);
    endtask

    task automatic t_busy;
        @(negedge clk); cmd_wr = 1; cmd_wdata = mk(0, 6, 1, 8'h11);
        @(negedge clk); cmd_wdata = mk(0, 6, 1, 8'h99);
        chk("R7 first in flight", {63'd0, cmd_rdata[63]}, 64'd1);
        @(negedge clk); cmd_wr = 0;
        @(negedge clk);
        chk("R7 completes on time", {63'd0, cmd_rdata[63]}, 64'd0);
        chk("R7 first data kept", {56'd0, data_o}, 64'h11);
    endtask

    task automatic t_novalid;
        logic [63:0] w;
        w = mk(0, 6, 1, 8'h77); w[63] = 1'b0;
        @(negedge clk); cmd_wr = 1; cmd_wdata = w;
        @(negedge clk); cmd_wr = 0;
        chk("R12 no launch", {63'd0, cmd_rdata[63]}, 64'd0);
        @(negedge clk); @(negedge clk);
        chk("R12 data unchanged", {56'd0, data_o}, 64'h11);
    endtask

    task automatic t_unused;
        do_cmd(mk(1, 0, 0, 8'h00), res);
        chk("R10 unused read", res, rslt(1, 0, 8'h00));
        do_cmd(mk(0, 6, 5, 8'hAA), res);
        chk("R10 data untouched", {56'd0, data_o}, 64'h11);
        chk("R10 clock bytes untouched", {48'd0, clkctl_o, sclhi_o}, 64'h2B18);
        do_cmd(mk(0, 2, 1, 8'hAA), res);
        chk("R10 primary 2 ignored", {56'd0, data_o}, 64'h11);
    endtask

    initial begin
        #(20 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_data;
        t_clk;
        t_scl;
        t_ctl;
        t_irq;
        t_rst;
        t_busy;
        t_novalid;
        t_unused;
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule